// File: doc/BRIEF.md
# Load-Reserved Reservation Monitor

This block watches one hart's load-reserved / store-conditional pairs and decides whether each store-conditional may succeed. A load-reserved records a reservation. The reservation holds the aligned 8-byte chunk the load touched, an 8-bit mask of the bytes it read, and a 64-byte aligned granule that forms the reservation set. A store-conditional is answered one cycle later with a code: zero means pass and any nonzero value means fail. The code also says why it failed. Every store-conditional consumes the reservation, whether it passes or fails.

Two snoop ports can cancel a live reservation. Stores from other harts cancel it if they land anywhere in the granule. Writes from devices that are not harts cancel it only when their byte enables overlap the exact bytes the load-reserved read. Such a device write elsewhere in the granule leaves the reservation standing. The reservation state is also driven out for debug.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset, `rsv_valid` and `rsp_valid` are 0 and `rsp_code` is 0.
- R2: A load-reserved sets `rsv_valid` at the next edge. `rsv_base` becomes the address with bits [2:0] cleared. `rsv_mask` becomes 8'hFF for a doubleword, 8'h0F for a word with address bit 2 clear, and 8'hF0 for a word with address bit 2 set. Mask bit i stands for byte i of the chunk. A new load-reserved replaces any earlier reservation.
- R3: `rsp_valid` is high for exactly the one cycle after each store-conditional request. `rsp_code` is 0 on a pass.
- R4: A store-conditional with no valid reservation returns code 1.
- R5: A store-conditional passes when all of its bytes lie in the reserved 64-byte granule, i.e. address bits above bit 5 match, whatever its offset or size. Otherwise it returns code 2.
- R6: Every store-conditional clears the reservation, so a second store-conditional with no load-reserved in between returns code 1.
- R7: A store from another hart anywhere in the reserved granule clears the reservation. A store outside the granule has no effect on it.
- R8: A device write clears the reservation only when it targets the reserved 8-byte chunk and its byte enables overlap `rsv_mask`. Any other device write leaves the reservation valid.
- R9: A cancelling snoop in the same cycle as a store-conditional takes priority, and the store-conditional returns code 3. Code 1 outranks code 3, which outranks code 2.
- R10: A load-reserved in the same cycle as a store-conditional or a snoop is ordered after them. The store-conditional is judged on the old reservation, and the new reservation is installed valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lr_valid | input | 1 | Load-reserved event |
| lr_addr | input | ADDR_W | Load-reserved address, naturally aligned |
| lr_dword | input | 1 | 1 = doubleword, 0 = word |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Store-conditional address |
| sc_dword | input | 1 | 1 = doubleword, 0 = word |
| hs_valid | input | 1 | Store seen from another hart |
| hs_addr | input | ADDR_W | Address of that store |
| dw_valid | input | 1 | Write seen from a non-hart device |
| dw_addr | input | ADDR_W | Address of the device write (8-byte chunk) |
| dw_be | input | 8 | Byte enables of the device write within the chunk |
| rsp_valid | output | 1 | Store-conditional response strobe |
| rsp_code | output | RSP_W | 0 pass, 1 no reservation, 2 outside set, 3 snooped away |
| rsv_valid | output | 1 | Reservation live |
| rsv_base | output | ADDR_W | Reserved chunk address |
| rsv_mask | output | 8 | Reserved bytes within the chunk |

## Verification
Word loads in both halves of a chunk and doubleword loads are paired with store-conditionals at other offsets and sizes within the granule and just past its edge. This separates a granule compare from an exact-address compare. Hart stores and device writes are placed inside the chunk, beside it in the same granule, and outside the granule. Device writes use enables that do and do not overlap the reserved bytes, so that the wide cancellation rule for harts can be told apart from the narrow one for devices. Same-cycle collisions of a load-reserved, a store-conditional and a snoop check the priority order. A long random run confined to a few granules is then compared every cycle against a behavioural model.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  localparam int CHUNK_BYTES = 8;

  typedef enum logic [1:0] {
    SC_PASS       = 2'd0,
    SC_NO_RSV     = 2'd1,
    SC_OUT_OF_SET = 2'd2,
    SC_SNOOPED    = 2'd3
  } sc_code_e;

  // bytes of an 8-byte chunk covered by a naturally aligned word/doubleword
  function automatic logic [CHUNK_BYTES-1:0] lr_byte_mask(input logic dword,
                                                          input logic upper);
    if (dword)      return 8'hFF;
    else if (upper) return 8'hF0;
    else            return 8'h0F;
  endfunction

  // last-byte offset of an access
  function automatic logic [2:0] access_span(input logic dword);
    return dword ? 3'd7 : 3'd3;
  endfunction

endpackage

// File: rtl/lrsc_rsv_reg.sv
module lrsc_rsv_reg
  import lrsc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lr_valid,
  input  logic [ADDR_W-1:0]      lr_addr,
  input  logic                   lr_dword,
  input  logic                   clear,
  output logic                   rsv_valid,
  output logic [ADDR_W-1:0]      rsv_base,
  output logic [CHUNK_BYTES-1:0] rsv_mask
);

  localparam logic [ADDR_W-1:0] CHUNK_LOW = ADDR_W'(CHUNK_BYTES - 1);

  logic [ADDR_W-1:0]      lr_base;
  logic [CHUNK_BYTES-1:0] lr_mask;
  logic                   lr_upper;

  assign lr_base  = lr_addr & ~CHUNK_LOW;
  assign lr_upper = lr_addr[2];
  assign lr_mask  = lr_byte_mask(lr_dword, lr_upper);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsv_valid <= 1'b0;
      rsv_base  <= '0;
      rsv_mask  <= '0;
    end else if (lr_valid) begin
      rsv_valid <= 1'b1;
      rsv_base  <= lr_base;
      rsv_mask  <= lr_mask;
    end else if (clear) begin
      rsv_valid <= 1'b0;
    end
  end

  AST_LR_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
    lr_valid |=> rsv_valid); // R2
  AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_valid |-> (rsv_mask == 8'h0F || rsv_mask == 8'hF0 || rsv_mask == 8'hFF)); // R2
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !lr_valid) |=> !rsv_valid); // R6

endmodule

// File: rtl/lrsc_snoop.sv
module lrsc_snoop
  import lrsc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LG2 = 6
) (
  input  logic                   rsv_valid,
  input  logic [ADDR_W-1:0]      rsv_base,
  input  logic [CHUNK_BYTES-1:0] rsv_mask,
  input  logic                   hs_valid,
  input  logic [ADDR_W-1:0]      hs_addr,
  input  logic                   dw_valid,
  input  logic [ADDR_W-1:0]      dw_addr,
  input  logic [CHUNK_BYTES-1:0] dw_be,
  output logic                   hart_kill,
  output logic                   dev_kill,
  output logic                   kill
);

  localparam int CHUNK_LG2 = $clog2(CHUNK_BYTES);

  logic                   hs_in_set;
  logic                   dw_in_chunk;
  logic [CHUNK_BYTES-1:0] byte_hit;

  assign hs_in_set   = (hs_addr >> GRAN_LG2) == (rsv_base >> GRAN_LG2);
  assign dw_in_chunk = (dw_addr >> CHUNK_LG2) == (rsv_base >> CHUNK_LG2);

  for (genvar b = 0; b < CHUNK_BYTES; b++) begin : g_byte
    assign byte_hit[b] = dw_be[b] & rsv_mask[b];
  end

  assign hart_kill = rsv_valid & hs_valid & hs_in_set;
  assign dev_kill  = rsv_valid & dw_valid & dw_in_chunk & (|byte_hit);
  assign kill      = hart_kill | dev_kill;

endmodule

// File: rtl/lrsc_sc_judge.sv
module lrsc_sc_judge
  import lrsc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LG2 = 6,
  parameter int RSP_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              sc_dword,
  input  logic              rsv_valid,
  input  logic [ADDR_W-1:0] rsv_base,
  input  logic              kill,
  output logic              rsp_valid,
  output logic [RSP_W-1:0]  rsp_code
);

  logic [ADDR_W-1:0] sc_last;
  logic              first_in, last_in, sc_in_set;
  sc_code_e          verdict;

  assign sc_last   = sc_addr + ADDR_W'(access_span(sc_dword));
  assign first_in  = (sc_addr >> GRAN_LG2) == (rsv_base >> GRAN_LG2);
  assign last_in   = (sc_last >> GRAN_LG2) == (rsv_base >> GRAN_LG2);
  assign sc_in_set = first_in & last_in;

  always_comb begin
    if (!rsv_valid)      verdict = SC_NO_RSV;
    else if (kill)       verdict = SC_SNOOPED;
    else if (!sc_in_set) verdict = SC_OUT_OF_SET;
    else                 verdict = SC_PASS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
    end else begin
      rsp_valid <= sc_valid;
      rsp_code  <= sc_valid ? RSP_W'(verdict) : '0;
    end
  end

  AST_NO_RSV_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !rsv_valid) |=> (rsp_code == RSP_W'(1))); // R4
  AST_SNOOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && rsv_valid && kill) |=> (rsp_code == RSP_W'(3))); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid |=> rsp_valid); // R3
  AST_RSP_ONLY_AFTER_SC: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_valid |=> !rsp_valid); // R3

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LG2 = 6,
  parameter int RSP_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lr_valid,
  input  logic [ADDR_W-1:0] lr_addr,
  input  logic              lr_dword,
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              sc_dword,
  input  logic              hs_valid,
  input  logic [ADDR_W-1:0] hs_addr,
  input  logic              dw_valid,
  input  logic [ADDR_W-1:0] dw_addr,
  input  logic [7:0]        dw_be,
  output logic              rsp_valid,
  output logic [RSP_W-1:0]  rsp_code,
  output logic              rsv_valid,
  output logic [ADDR_W-1:0] rsv_base,
  output logic [7:0]        rsv_mask
);

  logic hart_kill, dev_kill, kill, rsv_clear;

  assign rsv_clear = sc_valid | kill;

  lrsc_rsv_reg #(.ADDR_W(ADDR_W)) u_rsv (
    .clk(clk), .rst_n(rst_n),
    .lr_valid(lr_valid), .lr_addr(lr_addr), .lr_dword(lr_dword),
    .clear(rsv_clear),
    .rsv_valid(rsv_valid), .rsv_base(rsv_base), .rsv_mask(rsv_mask)
  );

  lrsc_snoop #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_snoop (
    .rsv_valid(rsv_valid), .rsv_base(rsv_base), .rsv_mask(rsv_mask),
    .hs_valid(hs_valid), .hs_addr(hs_addr),
    .dw_valid(dw_valid), .dw_addr(dw_addr), .dw_be(dw_be),
    .hart_kill(hart_kill), .dev_kill(dev_kill), .kill(kill)
  );

  lrsc_sc_judge #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2), .RSP_W(RSP_W)) u_judge (
    .clk(clk), .rst_n(rst_n),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_dword(sc_dword),
    .rsv_valid(rsv_valid), .rsv_base(rsv_base), .kill(kill),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code)
  );

  AST_HART_IN_SET_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && rsv_valid && !lr_valid &&
     ((hs_addr >> GRAN_LG2) == (rsv_base >> GRAN_LG2))) |=> !rsv_valid); // R7
  AST_DEV_OTHER_CHUNK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_valid && rsv_valid && !hs_valid && !sc_valid && !lr_valid &&
     ((dw_addr >> 3) != (rsv_base >> 3))) |=> rsv_valid); // R8
  AST_DEV_KILL_NEEDS_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    dev_kill |-> ((dw_be & rsv_mask) != 8'h00)); // R8
  AST_LR_SURVIVES_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_valid && (hart_kill || sc_valid)) |=> rsv_valid); // R10

endmodule

// File: tb/lrsc_monitor_tb.sv
module lrsc_monitor_tb;

  localparam int AW = 32;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lr_valid, lr_dword, sc_valid, sc_dword, hs_valid, dw_valid;
  logic [AW-1:0] lr_addr, sc_addr, hs_addr, dw_addr;
  logic [7:0]    dw_be;
  logic          rsp_valid, rsv_valid;
  logic [RW-1:0] rsp_code;
  logic [AW-1:0] rsv_base;
  logic [7:0]    rsv_mask;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // behavioural model state
  bit          m_valid = 0;
  int unsigned m_base  = 0;
  int unsigned m_mask  = 0;
  bit          e_rspv  = 0;
  int unsigned e_code  = 0;

  always #5 clk = ~clk;

  lrsc_monitor #(.ADDR_W(AW), .GRAN_LG2(6), .RSP_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lr_valid(lr_valid), .lr_addr(lr_addr), .lr_dword(lr_dword),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_dword(sc_dword),
    .hs_valid(hs_valid), .hs_addr(hs_addr),
    .dw_valid(dw_valid), .dw_addr(dw_addr), .dw_be(dw_be),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsv_valid(rsv_valid), .rsv_base(rsv_base), .rsv_mask(rsv_mask)
  );

  task automatic idle_inputs();
    lr_valid = 0; lr_addr = 0; lr_dword = 0;
    sc_valid = 0; sc_addr = 0; sc_dword = 0;
    hs_valid = 0; hs_addr = 0;
    dw_valid = 0; dw_addr = 0; dw_be = 0;
  endtask

  task automatic expect_eq(string req, string what, int unsigned act, int unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    expect_eq(req, "rsp_valid", rsp_valid, e_rspv);
    if (e_rspv) expect_eq(req, "rsp_code", rsp_code, e_code);
    expect_eq(req, "rsv_valid", rsv_valid, m_valid);
    if (m_valid) begin
      expect_eq(req, "rsv_base", rsv_base, m_base);
      expect_eq(req, "rsv_mask", rsv_mask, m_mask);
    end
  endtask

  // model: evaluate the current inputs against the current state, then clock
  task automatic step(string req);
    bit          killed;
    int unsigned g;
    g = m_base / 64;
    killed = m_valid && ((hs_valid && (hs_addr / 64) == g) ||
             (dw_valid && (dw_addr / 8) == (m_base / 8) && ((dw_be & m_mask) != 0)));
    e_rspv = sc_valid;
    if (sc_valid) begin
      if (!m_valid)     e_code = 1;
      else if (killed)  e_code = 3;
      else if ((sc_addr / 64) != g || ((sc_addr + (sc_dword ? 7 : 3)) / 64) != g) e_code = 2;
      else              e_code = 0;
    end
    if (lr_valid) begin
      m_valid = 1;
      m_base  = lr_addr - (lr_addr % 8);
      m_mask  = lr_dword ? 'hFF : (lr_addr[2] ? 'hF0 : 'h0F);
    end else if (sc_valid || killed) begin
      m_valid = 0;
    end
    @(posedge clk);
    #1;
    compare(req);
    idle_inputs();
  endtask

  task automatic do_lr(string req, int unsigned a, bit dw);
    lr_valid = 1; lr_addr = a; lr_dword = dw; step(req);
  endtask

  task automatic do_sc(string req, int unsigned a, bit dw);
    sc_valid = 1; sc_addr = a; sc_dword = dw; step(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    expect_eq("R1", "rsp_code", rsp_code, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R4: no reservation
    do_sc("R4", 'h1000, 0); step("R4");
    // R2: masks and base
    do_lr("R2", 'h1004, 0);
    do_lr("R2", 'h2008, 1);
    do_lr("R2", 'h3000, 0);
    // R3 / R5 pass in same granule at other offset and size, then R6
    do_lr("R3", 'h1000, 0);
    do_sc("R5", 'h1038, 1); step("R3");
    do_sc("R6", 'h1000, 0); step("R6");
    // R5 outside the granule
    do_lr("R5", 'h1000, 0);
    do_sc("R5", 'h1040, 0); step("R5");
    do_lr("R5", 'h103C, 0);
    do_sc("R5", 'h0FFC, 0); step("R5");
    // R7 hart store inside / outside granule
    do_lr("R7", 'h1000, 0);
    hs_valid = 1; hs_addr = 'h103C; step("R7");
    do_sc("R7", 'h1000, 0); step("R7");
    do_lr("R7", 'h1000, 0);
    hs_valid = 1; hs_addr = 'h1040; step("R7");
    do_sc("R7", 'h1000, 0); step("R7");
    // R8 device writes
    do_lr("R8", 'h1000, 0);
    dw_valid = 1; dw_addr = 'h1000; dw_be = 'hF0; step("R8");
    dw_valid = 1; dw_addr = 'h1008; dw_be = 'hFF; step("R8");
    do_sc("R8", 'h1000, 0); step("R8");
    do_lr("R8", 'h1004, 0);
    dw_valid = 1; dw_addr = 'h1000; dw_be = 'h10; step("R8");
    do_sc("R8", 'h1004, 0); step("R8");
    // R9 snoop and SC together; code 1 outranks code 3
    do_lr("R9", 'h1000, 1);
    sc_valid = 1; sc_addr = 'h1000; sc_dword = 1; hs_valid = 1; hs_addr = 'h1020; step("R9");
    step("R9");
    sc_valid = 1; sc_addr = 'h1000; hs_valid = 1; hs_addr = 'h1000; step("R9");
    do_lr("R9", 'h1000, 0);
    sc_valid = 1; sc_addr = 'h1080; dw_valid = 1; dw_addr = 'h1000; dw_be = 'h01; step("R9");
    // R10 LR ordered after SC / snoop
    do_lr("R10", 'h1000, 0);
    sc_valid = 1; sc_addr = 'h1000; lr_valid = 1; lr_addr = 'h2004; step("R10");
    step("R10");
    lr_valid = 1; lr_addr = 'h3000; lr_dword = 1; hs_valid = 1; hs_addr = 'h2000; step("R10");
    do_sc("R10", 'h3000, 1); step("R10");

    // random mix in a few granules
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom % 16;
      lr_dword = $urandom % 2;
      lr_addr  = 'h1000 + ($urandom % 192) * 4;
      if (lr_dword) lr_addr = lr_addr & ~32'h7;
      lr_valid = (r < 3);
      sc_dword = $urandom % 2;
      sc_addr  = 'h1000 + ($urandom % 192) * 4;
      if (sc_dword) sc_addr = sc_addr & ~32'h7;
      sc_valid = (r >= 3 && r < 6) || (r == 15);
      hs_valid = ($urandom % 8) == 0;
      hs_addr  = 'h1000 + ($urandom % 768);
      dw_valid = ($urandom % 5) == 0;
      dw_addr  = 'h1000 + ($urandom % 96) * 8;
      dw_be    = 8'($urandom);
      step("R2 R5 R7 R8 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule